// File: doc/BRIEF.md
# Command-Driven Random Word Generator Core

This core sits behind a simple register bus. Software starts work by writing a command code: one code asks for a fresh seed and another asks for a block of random output. The core shows its activity in a status word and holds the result in eight 32-bit output words. When a request is complete it raises a data-ready flag in a write-one-to-clear flag register. If the flag's enable and the global enable are both set, the flag also drives an interrupt line. A version register returns a fixed identifier.

The entropy source and the conditioning function are outside this block. Entropy arrives as a stream of 32-bit words with a valid strobe. During seeding the core sums the accepted words into a 32-bit key. During generation each accepted word is mixed with the key into one output word. The core seeds itself once after reset. It can also reseed by itself after a programmable number of served requests, and that reseed always runs before the next request is served.

Top module: `trng_core`

## Requirements
- R1: After reset the status word (0x04) has only the reseeding bit 31 set. The flag (0x14), enable (0x10), mode (0x08) and auto-reseed (0x60) registers read 0. After SEED_CYCLES cycles the status reads 0x0000_0200, which is only the seeded bit 9, and flag bit 1 (seed done) is set.
- R2: The register at 0xF0 reads 0x0000_46BC.
- R3: Writing 2 to the command register (0x00) seeds the core. For SEED_CYCLES cycles the status reads 0x8000_0200. The key becomes the mod-2^32 sum of the entropy words that are valid in those cycles. When seeding ends, flag bit 1 is set, the seeded bit stays set and the request counter is cleared.
- R4: Writing 1 to the command register sets status bit 30 (generating). On each cycle with valid entropy the core fills the next output word k (at 0x20+4k) with entropy XOR (key + k). After the last word the core sets flag bit 0 and the status returns to 0x0000_0200.
- R5: Mode bit 3 selects the result size: 1 fills all eight words, 0 fills words 0 to 3. A request with bit 3 at 0 clears words 4 to 7 when it starts.
- R6: A command written while bit 30 or bit 31 of the status is set is ignored. A command value above 2 is always ignored.
- R7: Writing 0 to the command register while a result is held returns the core to idle and leaves the output words unchanged.
- R8: Writing 1 to a bit of the flag register clears that bit. If an event sets the same bit in the same cycle, the bit stays set.
- R9: If the auto-reseed register holds L, which is not 0, and L or more requests have completed since the last seed, a request with command 1 first reseeds. During that reseed the status reads 0x8000_0200 and the counter restarts at 0. The core then generates from the new key and sets flag bits 0 and 1. L = 0 turns the auto-reseed off.
- R10: The interrupt output is high exactly when enable bit 31 is set and a flag bit is set whose enable bit is set: enable bit 0 pairs with flag bit 0, and enable bit 1 pairs with flag bit 1.
- R11: The mode register keeps only bit 3, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ent_valid | input | 1 | Entropy word valid |
| ent_data | input | 32 | Entropy word |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the flag register in the same clock edge: a request finishing, which sets data-ready, and a software write of one, which clears it. The bench runs a 128-bit request with continuous entropy, so it knows the exact edge on which the fourth word is stored. It times a clear write to land on that edge. The bench then checks that the ready bit is still set and that the words hold their expected values, with the upper four words cleared.

// File: rtl/trng_pkg.sv
package trng_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_CMD   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_MODE  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_IEN   = 8'h10;
    localparam logic [REG_AW-1:0] OFS_IFLG  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_WORD0 = 8'h20;
    localparam logic [REG_AW-1:0] OFS_AUTO  = 8'h60;
    localparam logic [REG_AW-1:0] OFS_VER   = 8'hF0;

    localparam int STAT_SEEDED_BIT = 9;
    localparam int STAT_GEN_BIT    = 30;
    localparam int STAT_RESEED_BIT = 31;
    localparam int MODE_WIDE_BIT   = 3;
    localparam int IEN_GLOBAL_BIT  = 31;
    localparam int FLG_W           = 2;

    localparam logic [REG_DW-1:0] VERSION_ID = 32'h0000_46BC;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_RAND = 2'd1,
        CMD_SEED = 2'd2,
        CMD_RSVD = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_GEN,
        ST_HOLD
    } fsm_e;

    typedef struct packed {
        logic valid;
        cmd_e code;
    } cmd_req_t;

    typedef struct packed {
        logic seeded;
        logic generating;
        logic reseeding;
    } core_stat_t;

    typedef struct packed {
        logic seed_done;
        logic gen_done;
    } core_evt_t;

    function automatic cmd_req_t decode_cmd(input logic [REG_DW-1:0] v);
        cmd_req_t r;
        r.valid = (v < 32'd3);
        r.code  = cmd_e'(v[1:0]);
        return r;
    endfunction

    function automatic logic [REG_DW-1:0] pack_status(input core_stat_t s);
        logic [REG_DW-1:0] w;
        w = '0;
        w[STAT_SEEDED_BIT] = s.seeded;
        w[STAT_GEN_BIT]    = s.generating;
        w[STAT_RESEED_BIT] = s.reseeding;
        return w;
    endfunction

    function automatic logic [REG_DW-1:0] mix_word(input logic [REG_DW-1:0] ent,
                                                   input logic [REG_DW-1:0] key,
                                                   input int unsigned idx);
        return ent ^ (key + REG_DW'(idx));
    endfunction

endpackage

// File: rtl/trng_ctrl.sv
module trng_ctrl
    import trng_pkg::*;
#(
    parameter int SEED_CYCLES = 16,
    parameter int NUM_WORDS   = 8,
    parameter int AUTO_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  cmd_req_t                     cmd,
    input  logic                         mode_wide,
    input  logic [AUTO_W-1:0]            auto_lim,
    input  logic                         ent_valid,
    output core_stat_t                   stat,
    output core_evt_t                    evt,
    output logic                         seed_clr,
    output logic                         seed_act,
    output logic                         gen_start,
    output logic                         start_wide,
    output logic                         wr_en,
    output logic [$clog2(NUM_WORDS)-1:0] wr_idx
);

    localparam int CYC_W = $clog2(SEED_CYCLES + 1);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int HALF  = NUM_WORDS / 2;

    fsm_e              st_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wide_q;
    logic              chain_q;
    logic              seeded_q;
    logic [AUTO_W-1:0] req_q;

    logic             busy;
    logic             accept;
    logic             want_rand;
    logic             want_seed;
    logic             want_idle;
    logic             reseed_due;
    logic             seed_fin;
    logic             gen_fin;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        busy       = (st_q == ST_SEED) || (st_q == ST_GEN);
        accept     = cmd.valid && !busy;
        want_rand  = accept && (cmd.code == CMD_RAND);
        want_seed  = accept && (cmd.code == CMD_SEED);
        want_idle  = accept && (cmd.code == CMD_NOP) && (st_q == ST_HOLD);
        reseed_due = (auto_lim != '0) && (req_q >= auto_lim);
        last_idx   = wide_q ? IDX_W'(NUM_WORDS - 1) : IDX_W'(HALF - 1);
        seed_fin   = (st_q == ST_SEED) && (cyc_q == CYC_W'(SEED_CYCLES - 1));
        gen_fin    = (st_q == ST_GEN) && ent_valid && (idx_q == last_idx);
    end

    always_comb begin
        seed_clr   = want_seed || (want_rand && reseed_due);
        seed_act   = (st_q == ST_SEED);
        gen_start  = (want_rand && !reseed_due) || (seed_fin && chain_q);
        start_wide = want_rand ? mode_wide : wide_q;
        wr_en      = (st_q == ST_GEN) && ent_valid;
        wr_idx     = idx_q;

        stat.seeded     = seeded_q;
        stat.generating = (st_q == ST_GEN);
        stat.reseeding  = (st_q == ST_SEED);
        evt.seed_done   = seed_fin;
        evt.gen_done    = gen_fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_SEED;
            cyc_q    <= '0;
            idx_q    <= '0;
            wide_q   <= 1'b0;
            chain_q  <= 1'b0;
            seeded_q <= 1'b0;
            req_q    <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_HOLD: begin
                    if (want_seed) begin
                        st_q    <= ST_SEED;
                        cyc_q   <= '0;
                        chain_q <= 1'b0;
                        req_q   <= '0;
                    end else if (want_rand) begin
                        wide_q <= mode_wide;
                        if (reseed_due) begin
                            st_q    <= ST_SEED;
                            cyc_q   <= '0;
                            chain_q <= 1'b1;
                            req_q   <= '0;
                        end else begin
                            st_q  <= ST_GEN;
                            idx_q <= '0;
                        end
                    end else if (want_idle) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_SEED: begin
                    if (seed_fin) begin
                        seeded_q <= 1'b1;
                        cyc_q    <= '0;
                        chain_q  <= 1'b0;
                        if (chain_q) begin
                            st_q  <= ST_GEN;
                            idx_q <= '0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                ST_GEN: begin
                    if (gen_fin) begin
                        st_q  <= ST_HOLD;
                        idx_q <= '0;
                        if (req_q != '1) begin
                            req_q <= req_q + 1'b1;
                        end
                    end else if (ent_valid) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trng_outbuf.sv
module trng_outbuf
    import trng_pkg::*;
#(
    parameter int NUM_WORDS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  ent_valid,
    input  logic [REG_DW-1:0]                     ent_data,
    input  logic                                  seed_clr,
    input  logic                                  seed_act,
    input  logic                                  gen_start,
    input  logic                                  start_wide,
    input  logic                                  wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0]          wr_idx,
    output logic [NUM_WORDS-1:0][REG_DW-1:0]      words
);

    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int HALF  = NUM_WORDS / 2;

    logic [REG_DW-1:0] key_q;

    always_ff @(posedge clk) begin
        if (rst || seed_clr) begin
            key_q <= '0;
        end else if (seed_act && ent_valid) begin
            key_q <= key_q + ent_data;
        end
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam bit UPPER = (k >= HALF);
        logic [REG_DW-1:0] w_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                w_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                w_q <= mix_word(ent_data, key_q, k);
            end else if (gen_start && !start_wide && UPPER) begin
                w_q <= '0;
            end
        end

        assign words[k] = w_q;
    end

endmodule

// File: rtl/trng_regs.sv
module trng_regs
    import trng_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int AUTO_W    = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_we,
    input  logic [REG_AW-1:0]                reg_addr,
    input  logic [REG_DW-1:0]                reg_wdata,
    output logic [REG_DW-1:0]                reg_rdata,
    input  core_stat_t                       stat,
    input  core_evt_t                        evt,
    input  logic [NUM_WORDS-1:0][REG_DW-1:0] words,
    output cmd_req_t                         cmd,
    output logic                             mode_wide,
    output logic [AUTO_W-1:0]                auto_lim,
    output logic [FLG_W-1:0]                 iflg,
    output logic                             ien_glb,
    output logic                             irq
);

    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam logic [REG_AW-1:0] WIN = REG_AW'(NUM_WORDS * 4);

    logic              mode_q;
    logic              glb_q;
    logic [FLG_W-1:0]  ien_q;
    logic [FLG_W-1:0]  flg_q;
    logic [AUTO_W-1:0] auto_q;

    logic              wr_cmd, wr_mode, wr_ien, wr_flg, wr_auto;
    logic [FLG_W-1:0]  flg_clr;
    logic [FLG_W-1:0]  flg_set;
    logic [REG_AW-1:0] wofs;
    logic [IDX_W-1:0]  widx;
    logic              in_win;

    always_comb begin
        wr_cmd  = reg_we && (reg_addr == OFS_CMD);
        wr_mode = reg_we && (reg_addr == OFS_MODE);
        wr_ien  = reg_we && (reg_addr == OFS_IEN);
        wr_flg  = reg_we && (reg_addr == OFS_IFLG);
        wr_auto = reg_we && (reg_addr == OFS_AUTO);

        cmd       = decode_cmd(reg_wdata);
        cmd.valid = cmd.valid && wr_cmd;

        flg_clr = wr_flg ? reg_wdata[FLG_W-1:0] : '0;
        flg_set = {evt.seed_done, evt.gen_done};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            glb_q  <= 1'b0;
            ien_q  <= '0;
            flg_q  <= '0;
            auto_q <= '0;
        end else begin
            if (wr_mode) mode_q <= reg_wdata[MODE_WIDE_BIT];
            if (wr_ien) begin
                glb_q <= reg_wdata[IEN_GLOBAL_BIT];
                ien_q <= reg_wdata[FLG_W-1:0];
            end
            if (wr_auto) auto_q <= reg_wdata[AUTO_W-1:0];
            flg_q <= (flg_q & ~flg_clr) | flg_set;
        end
    end

    always_comb begin
        wofs   = reg_addr - OFS_WORD0;
        widx   = wofs[IDX_W+1:2];
        in_win = (reg_addr >= OFS_WORD0) && (wofs < WIN) && (reg_addr[1:0] == 2'b00);

        reg_rdata = '0;
        if (reg_addr == OFS_STAT) begin
            reg_rdata = pack_status(stat);
        end else if (reg_addr == OFS_MODE) begin
            reg_rdata[MODE_WIDE_BIT] = mode_q;
        end else if (reg_addr == OFS_IEN) begin
            reg_rdata[IEN_GLOBAL_BIT] = glb_q;
            reg_rdata[FLG_W-1:0]      = ien_q;
        end else if (reg_addr == OFS_IFLG) begin
            reg_rdata[FLG_W-1:0] = flg_q;
        end else if (reg_addr == OFS_AUTO) begin
            reg_rdata = {{(REG_DW-AUTO_W){1'b0}}, auto_q};
        end else if (reg_addr == OFS_VER) begin
            reg_rdata = VERSION_ID;
        end else if (in_win) begin
            reg_rdata = words[widx];
        end
    end

    assign mode_wide = mode_q;
    assign auto_lim  = auto_q;
    assign iflg      = flg_q;
    assign ien_glb   = glb_q;
    assign irq       = glb_q && |(ien_q & flg_q);

endmodule

// File: rtl/trng_core.sv
module trng_core
    import trng_pkg::*;
#(
    parameter int SEED_CYCLES = 16,
    parameter int NUM_WORDS   = 8,
    parameter int AUTO_W      = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ent_valid,
    input  logic [31:0] ent_data,
    output logic        irq
);

    localparam int IDX_W = $clog2(NUM_WORDS);

    cmd_req_t                         cmd;
    core_stat_t                       stat;
    core_evt_t                        evt;
    logic                             mode_wide;
    logic [AUTO_W-1:0]                auto_lim;
    logic                             seed_clr, seed_act, gen_start, start_wide, wr_en;
    logic [IDX_W-1:0]                 wr_idx;
    logic [NUM_WORDS-1:0][REG_DW-1:0] words;
    logic [FLG_W-1:0]                 iflg;
    logic                             ien_glb;
    logic                             sts_seeded, sts_gen, sts_reseed;

    trng_ctrl #(
        .SEED_CYCLES(SEED_CYCLES),
        .NUM_WORDS  (NUM_WORDS),
        .AUTO_W     (AUTO_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .mode_wide (mode_wide),
        .auto_lim  (auto_lim),
        .ent_valid (ent_valid),
        .stat      (stat),
        .evt       (evt),
        .seed_clr  (seed_clr),
        .seed_act  (seed_act),
        .gen_start (gen_start),
        .start_wide(start_wide),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx)
    );

    trng_outbuf #(
        .NUM_WORDS(NUM_WORDS)
    ) u_outbuf (
        .clk       (clk),
        .rst       (rst),
        .ent_valid (ent_valid),
        .ent_data  (ent_data),
        .seed_clr  (seed_clr),
        .seed_act  (seed_act),
        .gen_start (gen_start),
        .start_wide(start_wide),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .words     (words)
    );

    trng_regs #(
        .NUM_WORDS(NUM_WORDS),
        .AUTO_W   (AUTO_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .stat     (stat),
        .evt      (evt),
        .words    (words),
        .cmd      (cmd),
        .mode_wide(mode_wide),
        .auto_lim (auto_lim),
        .iflg     (iflg),
        .ien_glb  (ien_glb),
        .irq      (irq)
    );

    assign sts_seeded = stat.seeded;
    assign sts_gen    = stat.generating;
    assign sts_reseed = stat.reseeding;

endmodule

// File: rtl/trng_core_chk.sv
module trng_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       sts_seeded,
    input logic       sts_gen,
    input logic       sts_reseed,
    input logic [1:0] iflg,
    input logic       ien_glb,
    input logic       irq
);

    AST_RESET_SEEDS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sts_reseed && !sts_gen && !sts_seeded)); // R1

    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
        !(sts_gen && sts_reseed)); // R9

    AST_SEEDED_STAYS: assert property (@(posedge clk) disable iff (rst)
        sts_seeded |=> sts_seeded); // R3

    AST_SEED_END_FLAG: assert property (@(posedge clk) disable iff (rst)
        $fell(sts_reseed) |-> (iflg[1] && sts_seeded)); // R3

    AST_GEN_END_FLAG: assert property (@(posedge clk) disable iff (rst)
        $fell(sts_gen) |-> iflg[0]); // R8

    AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        !ien_glb |-> !irq); // R10

endmodule

bind trng_core trng_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sts_seeded(sts_seeded),
    .sts_gen   (sts_gen),
    .sts_reseed(sts_reseed),
    .iflg      (iflg),
    .ien_glb   (ien_glb),
    .irq       (irq)
);

// File: tb/trng_core_tb.sv
module trng_core_tb;

    localparam int SEEDC = 16;
    localparam int NW    = 8;
    localparam logic [31:0] S_SEEDED = 32'h0000_0200;
    localparam logic [31:0] S_GEN    = 32'h4000_0000;
    localparam logic [31:0] S_RESEED = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ent_valid = 1'b1;
    logic [31:0] ent_data = '0;
    logic        irq;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    logic [31:0] key;

    always #10 clk = ~clk;

    trng_core u_dut (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ent_valid(ent_valid),
        .ent_data (ent_data),
        .irq      (irq)
    );

    // monitor: pops the expected item and compares against the sampled port
    always @(mon_ev) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : reg_rdata;
        n_chk++;
        if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: addr %h actual %h expected %h", it.tag, it.addr, act, it.exp);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #5 ->mon_ev;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        reg_we = 1'b0;
        it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        #5 ->mon_ev;
    endtask

    task automatic wait_ready(input string tag);
        bit ok = 0;
        for (int i = 0; i < 200 && !ok; i++) begin
            @(negedge clk);
            reg_we = 1'b0; reg_addr = 8'h04;
            #1;
            if ((reg_rdata & 32'hC000_0200) == S_SEEDED) ok = 1;
        end
        if (!ok) begin
            n_chk++; n_fail++;
            $display("FAIL %s: actual status %h expected %h", tag, reg_rdata, S_SEEDED);
        end
    endtask

    task automatic check_words(input logic [31:0] d, input int nfill, input string tag);
        for (int k = 0; k < NW; k++) begin
            exp_reg(8'h20 + 8'(4 * k), (k < nfill) ? (d ^ (key + 32'(k))) : 32'h0, tag);
        end
    endtask

    initial begin
        logic [31:0] d0, d1, d2, d3, d4, d5;
        d0 = 32'h1357_9BDF; d1 = 32'hA5A5_0F0F; d2 = 32'h0F1E_2D3C;
        d3 = 32'h7777_1234; d4 = 32'hC3C3_5A5A; d5 = 32'h0BAD_F00D;
        ent_data = d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 version
        exp_reg(8'h04, S_RESEED, "R1 status after reset");
        exp_reg(8'h14, 32'h0, "R1 flags after reset");
        exp_reg(8'h10, 32'h0, "R1 enables after reset");
        exp_reg(8'h08, 32'h0, "R1 mode after reset");
        exp_reg(8'h60, 32'h0, "R1 auto limit after reset");
        exp_reg(8'hF0, 32'h0000_46BC, "R2 version");
        key = d0 * 32'(SEEDC);
        wait_ready("R1 power-on seed");
        exp_reg(8'h04, S_SEEDED, "R1 seeded only");
        exp_reg(8'h14, 32'h2, "R1 seed-done flag");
        wr(8'h14, 32'h2);
        exp_reg(8'h14, 32'h0, "R8 write-one clears");

        // R11 mode register keeps bit 3 only
        wr(8'h08, 32'hFFFF_FFFF);
        exp_reg(8'h08, 32'h8, "R11 mode readback");

        // R4 256-bit request, R6 seed command while generating ignored
        ent_data = d1;
        wr(8'h00, 32'h1);
        exp_reg(8'h04, S_GEN | S_SEEDED, "R4 generating");
        wr(8'h00, 32'h2);
        wait_ready("R4 gen done");
        exp_reg(8'h14, 32'h1, "R6 seed during gen ignored");
        exp_reg(8'h04, S_SEEDED, "R4 status back");
        check_words(d1, 8, "R4 word value");

        // R10 interrupt
        wr(8'h10, 32'h0000_0001);
        exp_irq(1'b0, "R10 no global enable");
        wr(8'h10, 32'h8000_0001);
        exp_irq(1'b1, "R10 ready irq");
        wr(8'h10, 32'h8000_0002);
        exp_irq(1'b0, "R10 seed irq without flag");
        exp_reg(8'h10, 32'h8000_0002, "R10 enable readback");

        // R7 NOP keeps words; R6 reserved code ignored
        wr(8'h00, 32'h0);
        exp_reg(8'h20, d1 ^ key, "R7 word0 after nop");
        exp_reg(8'h3C, d1 ^ (key + 32'd7), "R7 word7 after nop");
        wr(8'h00, 32'h3);
        exp_reg(8'h04, S_SEEDED, "R6 reserved code ignored");
        exp_reg(8'h20, d1 ^ key, "R6 word0 after reserved code");
        wr(8'h14, 32'h1);
        exp_reg(8'h14, 32'h0, "R8 clear ready flag");

        // R8 set/clear collision with R5 128-bit request
        wr(8'h08, 32'h0);
        ent_data = d2;
        wr(8'h00, 32'h1);
        repeat (2) @(negedge clk);
        wr(8'h14, 32'h1);
        exp_reg(8'h14, 32'h1, "R8 set wins over clear");
        exp_reg(8'h04, S_SEEDED, "R5 status after short request");
        check_words(d2, 4, "R5 short result");
        wr(8'h14, 32'h3);

        // R3 explicit seed; R6 rand during seed ignored
        ent_data = d3;
        wr(8'h00, 32'h2);
        wr(8'h00, 32'h1);
        exp_reg(8'h04, S_RESEED | S_SEEDED, "R3 reseeding");
        wait_ready("R3 seed done");
        key = d3 * 32'(SEEDC);
        exp_reg(8'h14, 32'h2, "R3 seed flag, R6 rand ignored");
        wr(8'h14, 32'h3);

        // R9 auto-reseed after two requests
        wr(8'h60, 32'h2);
        exp_reg(8'h60, 32'h2, "R9 limit readback");
        wr(8'h08, 32'h8);
        ent_data = d4;
        wr(8'h00, 32'h1);
        wait_ready("R9 first request");
        wr(8'h00, 32'h1);
        wait_ready("R9 second request");
        check_words(d4, 8, "R9 old key used");
        wr(8'h14, 32'h3);
        ent_data = d5;
        wr(8'h00, 32'h1);
        exp_reg(8'h04, S_RESEED | S_SEEDED, "R9 reseed before serving");
        wait_ready("R9 chained request");
        key = d5 * 32'(SEEDC);
        exp_reg(8'h14, 32'h3, "R9 both flags");
        check_words(d5, 8, "R9 new key used");
        wr(8'h00, 32'h1);
        exp_reg(8'h04, S_GEN | S_SEEDED, "R9 counter restarted");
        wait_ready("R9 last request");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule